// File: doc/BRIEF.md
# Glitch-Free Two-Rate Clock Divider

This block derives a processor clock from a fast free-running input clock. A single down-counter counts out one half-period of the output. When it reaches zero, a toggle flop inverts the output and the counter reloads with one of two fixed half-period lengths. A mode input chooses between a slow rate for start-up and a fast rate for normal running. With an 80 MHz input and the default lengths of 32 and 8 input clocks, the output runs at 1.25 MHz or 5 MHz.

The mode input is first registered in the fast clock domain. The reload logic reads it only when the counter is at zero. Because of this, a mode change made at any moment cannot shorten, lengthen or split the half-period in progress. The new rate starts cleanly at the next phase boundary. The output always has a 50% duty cycle, because the high and low halves are counted with the same reload value.

Top module: `clk_rate_div`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `cpu_clk` is low and the slow half-period length is armed.
- R2: After reset is released, the first phase is low and lasts exactly SLOW_HALF (32) input clocks before `cpu_clk` rises.
- R3: With `run_sel` held at 0, every high and every low phase lasts SLOW_HALF (32) input clocks, for a period of 64.
- R4: With `run_sel` held at 1, every high and every low phase lasts FAST_HALF (8) input clocks, for a period of 16.
- R5: Whatever the timing of `run_sel` changes, every output phase lasts exactly SLOW_HALF or FAST_HALF input clocks, never any other count.
- R6: A phase that has started keeps the length chosen at its start, even if `run_sel` changes part-way through it.
- R7: `run_sel` is registered on each rising edge of `clk_fast`. A phase that starts at edge E takes its length from the value of `run_sel` sampled at edge E-1. A change sampled first at edge E therefore governs only the phase after that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast free-running input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_sel | input | 1 | Rate select: 0 = slow start-up rate, 1 = fast run rate |
| cpu_clk | output | 1 | Divided processor clock, 50% duty cycle |

## Verification
The assertions take `run_sel` to be a level that is stable around each rising edge of `clk_fast`. They model its two-stage path to the reload decision, and they expect reset to be applied before the first edge. The bench keeps to this by changing `run_sel` and `rst_n` only a short time after a falling edge. Within that constraint, it moves `run_sel` at every phase offset, including the two edges just before a reload where the latency boundary lies. It also makes changes at random intervals, so the phase-length rules are exercised across all alignments.

// File: rtl/clk_rate_div.sv
module clk_rate_div #(
  parameter int SLOW_HALF = 32,
  parameter int FAST_HALF = 8
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic run_sel,
  output logic cpu_clk
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;
  localparam int CW   = $clog2(MAXH + 1);
  localparam logic [CW-1:0] SLOW_LD = CW'(SLOW_HALF - 1);
  localparam logic [CW-1:0] FAST_LD = CW'(FAST_HALF - 1);

  logic          mode_q;
  logic [CW-1:0] cnt;
  wire           at_end = (cnt == '0);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      cnt     <= SLOW_LD;
      cpu_clk <= 1'b0;
    end else begin
      mode_q <= run_sel;
      if (at_end) begin
        cnt     <= mode_q ? FAST_LD : SLOW_LD;
        cpu_clk <= ~cpu_clk;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

module clk_rate_div_chk #(
  parameter int SLOW_HALF = 32,
  parameter int FAST_HALF = 8
) (
  input logic clk_fast,
  input logic rst_n,
  input logic run_sel,
  input logic cpu_clk
);
  localparam int MAXH = (SLOW_HALF > FAST_HALF) ? SLOW_HALF : FAST_HALF;

  logic        prev_clk;
  logic        sel_d1, sel_d2;
  logic [15:0] len;
  logic [15:0] want_len;
  wire         edge_seen = (cpu_clk != prev_clk);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      prev_clk <= 1'b0;
      sel_d1   <= 1'b0;
      sel_d2   <= 1'b0;
      len      <= '0;
      want_len <= 16'(SLOW_HALF);
    end else begin
      prev_clk <= cpu_clk;
      sel_d1   <= run_sel;
      sel_d2   <= sel_d1;
      if (edge_seen) begin
        len      <= 16'd1;
        want_len <= sel_d2 ? 16'(FAST_HALF) : 16'(SLOW_HALF);
      end else if (len != 16'hFFFF) begin
        len <= len + 16'd1;
      end
    end
  end

  // R1
  always @(posedge clk_fast)
    if (!rst_n) reset_low_chk: assert (cpu_clk == 1'b0);

  // R5
  legal_len_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    edge_seen |-> (len == 16'(SLOW_HALF) || len == 16'(FAST_HALF)));

  // R5
  no_stretch_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    len <= 16'(MAXH));

  // R7
  rate_at_reload_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    edge_seen |-> (len == want_len));
endmodule

bind clk_rate_div clk_rate_div_chk #(.SLOW_HALF(SLOW_HALF), .FAST_HALF(FAST_HALF)) u_chk (
  .clk_fast(clk_fast), .rst_n(rst_n), .run_sel(run_sel), .cpu_clk(cpu_clk)
);

// File: tb/test_clk_rate_div.sv
module test_clk_rate_div;
  localparam int SLOW = 32;
  localparam int FAST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_sel = 1'b0;
  logic cpu_clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_chg = 0;
  int last_len = 0;
  int phase_no = 0;
  logic prev = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clk_rate_div #(.SLOW_HALF(SLOW), .FAST_HALF(FAST)) i_clk_rate_div (
    .clk_fast(clk), .rst_n(rst_n), .run_sel(run_sel), .cpu_clk(cpu_clk)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R5: every completed phase is checked here
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      last_chg = cyc;
      prev = cpu_clk;
    end else if (cpu_clk != prev) begin
      last_len = cyc - last_chg;
      last_chg = cyc;
      prev = cpu_clk;
      phase_no++;
      check(last_len == SLOW || last_len == FAST, "R5", last_len, FAST);
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic wait_toggle();
    int n = phase_no;
    while (phase_no == n) step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    run_sel = 1'b0;
    repeat (3) step();
    check(cpu_clk == 1'b0, "R1", cpu_clk, 0);
    rst_n = 1'b1;
    wait_toggle();
    check(last_len == SLOW, "R2", last_len, SLOW);
    check(cpu_clk == 1'b1, "R2", cpu_clk, 1);
  endtask

  task automatic t_slow();
    run_sel = 1'b0;
    repeat (3) wait_toggle();
    for (int i = 0; i < 3; i++) begin
      wait_toggle();
      check(last_len == SLOW, "R3", last_len, SLOW);
    end
  endtask

  task automatic t_fast();
    run_sel = 1'b1;
    repeat (3) wait_toggle();
    for (int i = 0; i < 4; i++) begin
      wait_toggle();
      check(last_len == FAST, "R4", last_len, FAST);
    end
  endtask

  task automatic t_midphase();
    run_sel = 1'b0;
    repeat (3) wait_toggle();
    repeat (10) step();
    run_sel = 1'b1;
    wait_toggle();
    check(last_len == SLOW, "R6 slow phase kept", last_len, SLOW);
    wait_toggle();
    check(last_len == FAST, "R6 next phase fast", last_len, FAST);
    repeat (3) step();
    run_sel = 1'b0;
    wait_toggle();
    check(last_len == FAST, "R6 fast phase kept", last_len, FAST);
    wait_toggle();
    check(last_len == SLOW, "R6 next phase slow", last_len, SLOW);
  endtask

  task automatic t_latency();
    run_sel = 1'b1;
    repeat (3) wait_toggle();
    wait_toggle();
    repeat (FAST - 1) step();
    run_sel = 1'b0;
    wait_toggle();
    check(last_len == FAST, "R7 late current", last_len, FAST);
    wait_toggle();
    check(last_len == FAST, "R7 late next keeps old", last_len, FAST);
    wait_toggle();
    check(last_len == SLOW, "R7 late then new", last_len, SLOW);
    repeat (SLOW - 2) step();
    run_sel = 1'b1;
    wait_toggle();
    check(last_len == SLOW, "R7 early current", last_len, SLOW);
    wait_toggle();
    check(last_len == FAST, "R7 early next new", last_len, FAST);
  endtask

  task automatic t_random();
    int n0 = phase_no;
    for (int i = 0; i < 120; i++) begin
      repeat (1 + ($urandom % 45)) step();
      run_sel = ~run_sel;
    end
    check(phase_no - n0 > 50, "R5 phases seen", phase_no - n0, 51);
  endtask

  initial begin
    t_reset();
    t_slow();
    t_fast();
    t_midphase();
    t_latency();
    t_random();
    t_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule